// File: doc/BRIEF.md
# Mixed-Page-Size First-Level Translation Buffer

This block is a first-level translation buffer with 48 entries that sits beside a load/store or instruction-fetch pipeline. Any entry can hold any translation. Each entry maps a virtual page to a physical page, and the page may be one of five sizes. Each entry also keeps a page-size code and three permission bits. A lookup presents a virtual address and an access kind. One clock later the block reports one of two results:

- a hit, with the physical address for the cache tag compare, and an abort flag when the stored permissions forbid the access;
- a miss request that carries the virtual address, so the next translation level can service it.

The next level returns translations through a fill port. A fill writes the lowest-numbered empty entry if one exists. When the buffer is full, a round-robin pointer picks the victim. A single invalidate-all input empties the buffer in one cycle.

The largest page size depends on a parameter. The instruction-side build (`IS_DATA=0`) uses 32MB as its largest page. The data-side build (`IS_DATA=1`) uses 512MB. For each entry, the tag compare ignores the virtual address bits below that entry's page size. Those same low bits pass straight through into the physical address.

Top module: `tlb_l1`

## Requirements
- R1: Every valid entry, whatever its index, takes part in each lookup. A lookup hits when at least one valid entry matches.
- R2: The page-size code `fill_size` selects the page size: 0 is 4KB, 1 is 16KB, 2 is 64KB, 3 is 2MB, and 4 is 32MB when `IS_DATA=0` or 512MB when `IS_DATA=1`. Codes 5 to 7 behave as 4KB. The tag compare ignores the virtual address bits below the entry's page size, including those bits of the stored `fill_vpn`.
- R3: On a hit, `rsp_pa` has two parts. Above the page offset it takes the stored frame number (`fill_pfn`, in units of 4KB). Below the page offset it takes the lookup address bits. Frame bits below the page size are ignored. On a miss, `rsp_pa` is 0.
- R4: The response outputs are registered. `rsp_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high. Each response describes the lookup of the previous cycle.
- R5: `lk_acc` encodes the access kind: 0 is read, 1 is write, 2 is execute, and 3 is read. In an entry's permission field, bit 0 allows read, bit 1 allows write and bit 2 allows execute. `rsp_abort` is high only on a hit whose required permission bit is 0.
- R6: On a miss, `rsp_hit` and `rsp_abort` are low and `miss_req` is high. In that case `miss_va` equals the looked-up virtual address.
- R7: A fill writes the lowest-numbered invalid entry if there is one. Otherwise it writes the entry under the round-robin pointer. The pointer starts at 0, advances by one only on such a replacement, wraps from 47 to 0, and is not changed by invalidate-all.
- R8: If several valid entries match, the response comes from the lowest-numbered matching entry.
- R9: Invalidate-all clears every entry in one cycle and takes priority over a fill in the same cycle, so that fill is lost. A lookup in the same cycle as an invalidate or a fill sees the contents from before that edge.
- R10: Reset empties the buffer, sets the round-robin pointer to 0 and drives every response output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_acc | input | 2 | Access kind (0/3 read, 1 write, 2 execute) |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-12 | Virtual page number of the fill, 4KB units |
| fill_pfn | input | PA_W-12 | Physical frame number of the fill, 4KB units |
| fill_size | input | 3 | Page-size code of the fill |
| fill_perm | input | 3 | Permission bits of the fill {execute, write, read} |
| inval_all | input | 1 | Clear every entry |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_abort | output | 1 | Permission violation on a hit |
| miss_req | output | 1 | Miss to be serviced by the next level |
| miss_va | output | VA_W | Virtual address of the miss |

## Verification
The embedded assertions check several rules on every clock:

- the one-cycle response timing;
- that hit and miss exclude each other, and that an abort never appears without a hit;
- that the page-offset bits of a hit and the missed address match the lookup;
- that the priority encoders pick the lowest-numbered request;
- that an invalidate empties the whole buffer by the next edge;
- that the round-robin pointer holds still while an empty slot exists.

Other behaviours only the bench's scenarios can show, by comparing against a behavioural model on every cycle:

- the exact physical address for each page size;
- which entry a fill actually replaces over many fills;
- the outcome when translations overlap;
- the order of operations when invalidate, fill and lookup share a cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    PG_4K  = 3'd0,
    PG_16K = 3'd1,
    PG_64K = 3'd2,
    PG_2M  = 3'd3,
    PG_BIG = 3'd4
  } pg_size_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RD2 = 2'd3
  } acc_e;

  // Log2 of the page size in bytes; unknown codes fall back to 4KB (R2).
  function automatic int unsigned pg_shift(input logic [2:0] sz, input bit is_data);
    case (pg_size_e'(sz))
      PG_16K:  return 14;
      PG_64K:  return 16;
      PG_2M:   return 21;
      PG_BIG:  return is_data ? 29 : 25;
      default: return 12;
    endcase
  endfunction

  // Byte mask of the in-page offset.
  function automatic logic [63:0] off_mask(input logic [2:0] sz, input bit is_data);
    return (64'd1 << pg_shift(sz, is_data)) - 64'd1;
  endfunction

  // Permission bit required by an access kind (R5).
  function automatic logic acc_allowed(input logic [2:0] perm, input logic [1:0] acc);
    case (acc_e'(acc))
      ACC_WR:  return perm[1];
      ACC_EX:  return perm[2];
      default: return perm[0];
    endcase
  endfunction

endpackage

// File: rtl/tlb_first_sel.sv
module tlb_first_sel #(
  parameter int N = 48,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  // R8: the chosen index is requesting and no lower index is
  p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

  // R1: no selection is reported while a request is pending
  p_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (req == '0));

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N       = 48,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter bit IS_DATA = 1'b1,
  localparam int IW = $clog2(N),
  localparam int TW = VA_W - 12,
  localparam int FW = PA_W - 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] lk_vpn,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_vpn,
  input  logic [FW-1:0] wr_pfn,
  input  logic [2:0]    wr_size,
  input  logic [2:0]    wr_perm,
  input  logic          inval,
  input  logic [IW-1:0] rd_idx,
  output logic [N-1:0]  match,
  output logic [N-1:0]  valid_vec,
  output logic [FW-1:0] rd_pfn,
  output logic [2:0]    rd_size,
  output logic [2:0]    rd_perm
);

  logic [N-1:0]  vld_q;
  logic [TW-1:0] tag_q  [N];
  logic [FW-1:0] pfn_q  [N];
  logic [2:0]    sz_q   [N];
  logic [2:0]    perm_q [N];

  // R9/R10: valid bits reset, cleared as a group; invalidate beats fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (inval) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inval) begin
      tag_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      sz_q[wr_idx]   <= wr_size;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  // R1/R2: every entry compares in parallel with its own size mask
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [TW-1:0] keep;
    assign keep     = TW'(~(tlb_pkg::off_mask(sz_q[g], IS_DATA) >> 12));
    assign match[g] = vld_q[g] && (((lk_vpn ^ tag_q[g]) & keep) == '0);
  end

  assign valid_vec = vld_q;
  assign rd_pfn    = pfn_q[rd_idx];
  assign rd_size   = sz_q[rd_idx];
  assign rd_perm   = perm_q[rd_idx];

  // R9: the whole buffer is empty one edge after an invalidate
  p_inval_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (vld_q == '0));

  // R7: the slot chosen for a fill is valid afterwards
  p_fill_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inval) |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/tlb_l1.sv
module tlb_l1 #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter bit IS_DATA = 1'b1,
  localparam int IW = $clog2(ENTRIES),
  localparam int TW = VA_W - 12,
  localparam int FW = PA_W - 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_va,
  input  logic [1:0]      lk_acc,
  input  logic            fill_en,
  input  logic [TW-1:0]   fill_vpn,
  input  logic [FW-1:0]   fill_pfn,
  input  logic [2:0]      fill_size,
  input  logic [2:0]      fill_perm,
  input  logic            inval_all,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_abort,
  output logic            miss_req,
  output logic [VA_W-1:0] miss_va
);

  // Named internal events
  logic [ENTRIES-1:0] match, valid_vec;
  logic [IW-1:0]      hit_idx, free_idx, wr_idx, rr_q;
  logic               hit_any, free_any, fill_take, rr_use, perm_ok;
  logic [FW-1:0]      sel_pfn;
  logic [2:0]         sel_size, sel_perm;
  logic [63:0]        off64;
  logic [PA_W-1:0]    pa_c;

  tlb_cam #(.N(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .IS_DATA(IS_DATA)) u_cam (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_va[VA_W-1:12]),
    .wr_en(fill_take), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
    .wr_size(fill_size), .wr_perm(fill_perm), .inval(inval_all),
    .rd_idx(hit_idx), .match(match), .valid_vec(valid_vec),
    .rd_pfn(sel_pfn), .rd_size(sel_size), .rd_perm(sel_perm)
  );

  // R8: lowest-numbered match wins
  tlb_first_sel #(.N(ENTRIES)) u_hit_sel (
    .clk(clk), .rst_n(rst_n), .req(match), .idx(hit_idx), .any(hit_any)
  );

  // R7: lowest-numbered empty slot
  tlb_first_sel #(.N(ENTRIES)) u_free_sel (
    .clk(clk), .rst_n(rst_n), .req(~valid_vec), .idx(free_idx), .any(free_any)
  );

  assign fill_take = fill_en && !inval_all;
  assign rr_use    = fill_take && !free_any;
  assign wr_idx    = free_any ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rr_q <= '0;
    else if (rr_use) rr_q <= (int'(rr_q) == ENTRIES - 1) ? '0 : rr_q + IW'(1);
  end

  // R3: frame bits above the page offset, address bits below it
  assign off64   = tlb_pkg::off_mask(sel_size, IS_DATA);
  assign pa_c    = PA_W'(({{(64-PA_W){1'b0}}, sel_pfn, 12'h000} & ~off64) |
                         ({{(64-VA_W){1'b0}}, lk_va} & off64));
  assign perm_ok = tlb_pkg::acc_allowed(sel_perm, lk_acc);

  // R4: single registered response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_abort <= 1'b0;
      miss_req  <= 1'b0;
      miss_va   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_any;
      rsp_abort <= lk_valid && hit_any && !perm_ok;
      rsp_pa    <= (lk_valid && hit_any) ? pa_c : '0;
      miss_req  <= lk_valid && !hit_any;
      if (lk_valid) miss_va <= lk_va;
    end
  end

  p_resp_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_resp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_abort_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> rsp_hit);
  p_hit_xor_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != miss_req));
  p_miss_va_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> (miss_va == $past(lk_va)));
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[11:0] == $past(lk_va[11:0])));
  p_rr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rr_q) < ENTRIES);
  p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && free_any) |=> $stable(rr_q));

endmodule

// File: tb/tb_tlb_l1.sv
`timescale 1ns/1ps
module tb_tlb_l1;
  localparam int N    = 48;
  localparam int VA_W = 48;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic lk_valid = 0, fill_en = 0, inval_all = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic [1:0]  lk_acc = '0;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_pfn = '0;
  logic [2:0]  fill_size = '0, fill_perm = '0;
  logic rsp_valid, rsp_hit, rsp_abort, miss_req;
  logic [PA_W-1:0] rsp_pa;
  logic [VA_W-1:0] miss_va;

  tlb_l1 #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .IS_DATA(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_size(fill_size),
    .fill_perm(fill_perm), .inval_all(inval_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_abort(rsp_abort), .miss_req(miss_req), .miss_va(miss_va)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R10";

  // Behavioural reference model
  bit          mv    [N];
  logic [63:0] mvpn  [N];
  logic [63:0] mpfn  [N];
  logic [2:0]  msz   [N];
  logic [2:0]  mperm [N];
  int          mrr = 0;
  bit          e_valid = 0, e_hit = 0, e_abort = 0;
  logic [63:0] e_pa = '0, e_va = '0;

  function automatic int page_log2(input logic [2:0] code);
    longint bytes;
    case (code)
      3'd1: bytes = 16 * 1024;
      3'd2: bytes = 64 * 1024;
      3'd3: bytes = 2 * 1024 * 1024;
      3'd4: bytes = 512 * 1024 * 1024;
      default: bytes = 4096;
    endcase
    return $clog2(bytes);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      mrr = 0; e_valid = 0; e_hit = 0; e_abort = 0; e_pa = '0;
    end else begin
      e_valid = lk_valid; e_hit = 0; e_abort = 0; e_pa = '0; e_va = 64'(lk_va);
      if (lk_valid) begin
        for (int i = 0; i < N; i++) begin
          if (!e_hit && mv[i]) begin
            int s;
            logic [63:0] va64, ebase;
            bit ok;
            s = page_log2(msz[i]);
            va64 = 64'(lk_va);
            ebase = mvpn[i] << 12;
            if ((va64 >> s) == (ebase >> s)) begin
              e_hit = 1;
              e_pa = ((((mpfn[i] << 12) >> s) << s) | (va64 % (64'd1 << s)))
                     & ((64'd1 << PA_W) - 1);
              ok = (lk_acc == 2'd1) ? mperm[i][1] :
                   (lk_acc == 2'd2) ? mperm[i][2] : mperm[i][0];
              e_abort = !ok;
            end
          end
        end
      end
      if (inval_all) begin
        for (int i = 0; i < N; i++) mv[i] = 0;
      end else if (fill_en) begin
        int slot;
        slot = -1;
        for (int i = 0; i < N; i++) if (slot < 0 && !mv[i]) slot = i;
        if (slot < 0) begin slot = mrr; mrr = (mrr + 1) % N; end
        mv[slot] = 1; mvpn[slot] = 64'(fill_vpn); mpfn[slot] = 64'(fill_pfn);
        msz[slot] = fill_size; mperm[slot] = fill_perm;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/%s actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R4", 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
        chk("R1", 64'(rsp_hit), 64'(e_hit));
        chk("R6", 64'(miss_req), 64'(!e_hit));
        chk("R5", 64'(rsp_abort), 64'(e_abort));
        chk("R3", 64'(rsp_pa), e_pa);
        if (!e_hit) chk("R6", 64'(miss_va), e_va);
      end
    end
  end

  task automatic step(input bit lv, input logic [47:0] va, input logic [1:0] acc,
                      input bit fe, input logic [35:0] vpn, input logic [27:0] pfn,
                      input logic [2:0] sz, input logic [2:0] pm, input bit inv);
    @(negedge clk);
    lk_valid = lv; lk_va = va; lk_acc = acc;
    fill_en = fe; fill_vpn = vpn; fill_pfn = pfn; fill_size = sz; fill_perm = pm;
    inval_all = inv;
  endtask

  task automatic look(input logic [47:0] va, input logic [1:0] acc);
    step(1, va, acc, 0, '0, '0, '0, '0, 0);
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [27:0] pfn,
                      input logic [2:0] sz, input logic [2:0] pm);
    step(0, '0, 0, 1, vpn, pfn, sz, pm, 0);
  endtask

  task automatic inval();
    step(0, '0, 0, 0, '0, '0, '0, '0, 1);
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, '0, '0, '0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", 64'(rsp_valid), 0);
    chk("R10", 64'(rsp_hit), 0);
    chk("R10", 64'(miss_req), 0);
    chk("R10", 64'(rsp_abort), 0);
    rst_n = 1'b1;
    look(48'h0000_1234_5678, 0);          // empty after reset: miss
    idle();

    phase = "R2";
    fill(36'h12345, 28'h0ABCD, 3'd0, 3'b111);
    fill(36'h20004, 28'h11117, 3'd1, 3'b111);
    fill(36'h30010, 28'h22225, 3'd2, 3'b111);
    fill(36'h40235, 28'h333FF, 3'd3, 3'b111);
    fill(36'h60000, 28'hC0000, 3'd4, 3'b111);
    fill(36'h70001, 28'h00999, 3'd5, 3'b111);
    look(48'h0000_1234_5ABC, 0);
    look(48'h0000_1234_6000, 0);
    look(48'h0000_2000_7FFC, 0);
    look(48'h0000_2000_8000, 0);
    look(48'h0000_3001_FFFF, 0);
    look(48'h0000_3002_0000, 0);
    look(48'h0000_403F_F123, 0);
    look(48'h0000_4040_0000, 0);
    look(48'h0000_7FFF_FFF0, 0);
    look(48'h0000_5FFF_FFFF, 0);
    look(48'h0000_7000_1FFF, 0);
    look(48'h0000_7000_2000, 0);
    look(48'h8000_6000_0000, 0);
    step(1, 48'h0000_0800_0123, 0, 1, 36'h08000, 28'h05555, 3'd0, 3'b111, 0);
    look(48'h0000_0800_0123, 0);

    phase = "R5";
    inval();
    fill(36'h00100, 28'h00200, 3'd0, 3'b001);
    fill(36'h00101, 28'h00201, 3'd0, 3'b110);
    for (int a = 0; a < 4; a++) look(48'h0000_0010_0040, 2'(a));
    for (int a = 0; a < 4; a++) look(48'h0000_0010_1040, 2'(a));
    look(48'h0000_0099_9000, 2'd1);

    phase = "R8";
    inval();
    fill(36'h00500, 28'h0AAAA, 3'd0, 3'b111);
    fill(36'h00400, 28'h0BBB0, 3'd3, 3'b001);
    look(48'h0000_0050_0123, 0);
    look(48'h0000_0050_1000, 0);
    look(48'h0000_0050_0123, 1);
    inval();
    fill(36'h00400, 28'h0BBB0, 3'd3, 3'b001);
    fill(36'h00500, 28'h0AAAA, 3'd0, 3'b111);
    look(48'h0000_0050_0123, 0);
    look(48'h0000_0050_0123, 1);

    phase = "R9";
    step(1, 48'h0000_0050_0123, 0, 0, '0, '0, '0, '0, 1);
    look(48'h0000_0050_0123, 0);
    step(0, '0, 0, 1, 36'h00777, 28'h01234, 3'd0, 3'b111, 1);
    look(48'h0000_0077_7000, 0);

    phase = "R7";
    inval();
    for (int i = 0; i < N; i++) fill(36'(36'h01000 + i), 28'(28'h02000 + i), 3'd0, 3'b111);
    for (int i = 0; i < 50; i++) fill(36'(36'h03000 + i), 28'(28'h04000 + i), 3'd0, 3'b101);
    for (int i = 0; i < N; i++) look(48'({36'(36'h01000 + i), 12'h010}), 0);
    for (int i = 0; i < 50; i++) look(48'({36'(36'h03000 + i), 12'h020}), 1);
    inval();
    fill(36'h05000, 28'h06000, 3'd0, 3'b111);
    fill(36'h05001, 28'h06001, 3'd0, 3'b111);
    look(48'h0000_0500_0000, 0);
    look(48'h0000_0500_1ABC, 0);

    phase = "R1";
    inval();
    for (int c = 0; c < 3000; c++) begin
      int k;
      k = $urandom % 100;
      if (k < 1)
        step(1, 48'({36'(36'h00100 + $urandom % 64), 12'($urandom)}), 2'($urandom),
             0, '0, '0, '0, '0, 1);
      else if (k < 20)
        step($urandom % 2, 48'({36'(36'h00100 + $urandom % 64), 12'($urandom)}), 2'($urandom),
             1, 36'(36'h00100 + $urandom % 64), 28'($urandom),
             3'(($urandom % 7 == 0) ? 4 : $urandom % 4), 3'($urandom), 0);
      else if (k < 85)
        look(48'({36'(36'h00100 + $urandom % 64), 12'($urandom)}), 2'($urandom));
      else
        idle();
    end
    idle();
    idle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule